// File: doc/BRIEF.md
# Burst Offset Sequencer

This block produces the low-order word offset for a short burst. A load captures a starting offset and the upper address bits in one cycle. Each advance then moves the offset to the next beat of the burst. The upper bits stay fixed until the next load.

Two beat orders are supported, and a static order input picks between them. In sequential order the offset counts up and wraps. In interleaved order each beat is the starting offset XOR the beat number. Both orders are relative to the loaded start, so a burst may begin on any beat.

Cycles in which advance is low are wait states: the offset does not change. A load always takes priority over an advance in the same cycle and restarts the burst.

Top module: `burst_seq_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `ofs_o` is 0 and `hi_o` is 0.
- R2: In the cycle after a clock edge with `load_i`=1, `ofs_o` equals the `start_i` sampled at that edge and `hi_o` equals the `hi_i` sampled at that edge.
- R3: With `mode_i`=0 (sequential order), each advance edge without load sets `ofs_o` to the previous `ofs_o` plus 1, modulo 2^OFS_W (with OFS_W=2: 01, 10, 11, 00).
- R4: With `mode_i`=1 (interleaved order), after k advances since the last load, `ofs_o` equals the loaded start XOR k (with start 10: 10, 11, 00, 01).
- R5: In either order, after 2^OFS_W advances since the last load (4 when OFS_W=2), `ofs_o` is again the loaded start.
- R6: An edge with `load_i`=0 and `adv_i`=0 leaves `ofs_o` unchanged (wait state), provided `mode_i` is held.
- R7: An edge with both `load_i`=1 and `adv_i`=1 behaves as a plain load: `ofs_o` becomes the new `start_i`, and the beat count restarts from zero.
- R8: `hi_o` changes only on a load edge. Advances and wait states leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Capture a new start offset and upper bits |
| adv_i | input | 1 | Step to the next beat |
| mode_i | input | 1 | Beat order: 0 sequential, 1 interleaved (tie high if unused) |
| start_i | input | OFS_W | Starting offset captured on load |
| hi_i | input | HI_W | Upper address bits captured on load |
| ofs_o | output | OFS_W | Current burst offset |
| hi_o | output | HI_W | Held upper address bits |

## Verification
The bench builds the block with OFS_W=2 and HI_W=8. With these values a full burst is four beats. Every starting offset in both orders, the wrap back to the start, and the combination of load with advance can therefore all be reached in a handful of cycles. This leaves room for several thousand random cycles that mix wait states, loads and order changes. The 8-bit upper field is wide enough that a value that is held by mistake, or captured at the wrong edge, shows up as a mismatch.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic {
        ORD_SEQUENTIAL  = 1'b0,
        ORD_INTERLEAVED = 1'b1
    } order_e;

    typedef struct packed {
        logic load;
        logic adv;
    } burst_ctl_t;

    function automatic order_e decode_order(input logic pin);
        return pin ? ORD_INTERLEAVED : ORD_SEQUENTIAL;
    endfunction

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
    parameter int OFS_W = 2,
    parameter int HI_W  = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [OFS_W-1:0] start_i,
    input  logic [HI_W-1:0]  hi_i,
    output logic [OFS_W-1:0] start_q,
    output logic [HI_W-1:0]  hi_q
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            start_q <= '0;
            hi_q    <= '0;
        end else if (load_i) begin
            start_q <= start_i;
            hi_q    <= hi_i;
        end
    end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
    import burst_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  burst_ctl_t       ctl_i,
    output logic [OFS_W-1:0] count_q
);
    localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

    always_ff @(posedge clk_i) begin
        if (rst_i)
            count_q <= '0;
        else if (ctl_i.load)
            count_q <= '0;
        else if (ctl_i.adv)
            count_q <= count_q + ONE;
    end
endmodule

// File: rtl/burst_ofs_map.sv
module burst_ofs_map
    import burst_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  order_e           order_i,
    input  logic [OFS_W-1:0] start_i,
    input  logic [OFS_W-1:0] count_i,
    output logic [OFS_W-1:0] ofs_o
);
    logic [OFS_W-1:0] seq_ofs;
    logic [OFS_W-1:0] ilv_ofs;

    assign seq_ofs = start_i + count_i;

    for (genvar b = 0; b < OFS_W; b++) begin : g_ilv
        assign ilv_ofs[b] = start_i[b] ^ count_i[b];
    end

    always_comb begin
        unique case (order_i)
            ORD_SEQUENTIAL:  ofs_o = seq_ofs;
            ORD_INTERLEAVED: ofs_o = ilv_ofs;
            default:         ofs_o = ilv_ofs;
        endcase
    end
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
    import burst_pkg::*;
#(
    parameter int OFS_W = 2,
    parameter int HI_W  = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic             adv_i,
    input  logic             mode_i,
    input  logic [OFS_W-1:0] start_i,
    input  logic [HI_W-1:0]  hi_i,
    output logic [OFS_W-1:0] ofs_o,
    output logic [HI_W-1:0]  hi_o
);
    burst_ctl_t       ctl;
    order_e           order;
    logic [OFS_W-1:0] start_q;
    logic [OFS_W-1:0] count_q;

    assign ctl.load = load_i;
    assign ctl.adv  = adv_i;
    assign order    = decode_order(mode_i);

    burst_base_reg #(.OFS_W(OFS_W), .HI_W(HI_W)) base_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (load_i),
        .start_i (start_i),
        .hi_i    (hi_i),
        .start_q (start_q),
        .hi_q    (hi_o)
    );

    burst_beat_cnt #(.OFS_W(OFS_W)) cnt_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .ctl_i   (ctl),
        .count_q (count_q)
    );

    burst_ofs_map #(.OFS_W(OFS_W)) map_i (
        .order_i (order),
        .start_i (start_q),
        .count_i (count_q),
        .ofs_o   (ofs_o)
    );
endmodule

// File: rtl/burst_seq_gen_chk.sv
module burst_seq_gen_chk #(
    parameter int OFS_W = 2,
    parameter int HI_W  = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             load_i,
    input logic             adv_i,
    input logic             mode_i,
    input logic [OFS_W-1:0] start_i,
    input logic [HI_W-1:0]  hi_i,
    input logic [OFS_W-1:0] ofs_o,
    input logic [HI_W-1:0]  hi_o
);
    logic [OFS_W-1:0] beats_seen;
    logic [OFS_W-1:0] start_seen;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            beats_seen <= '0;
            start_seen <= '0;
        end else if (load_i) begin
            beats_seen <= '0;
            start_seen <= start_i;
        end else if (adv_i) begin
            beats_seen <= beats_seen + OFS_W'(1);
        end
    end

    // R2 and R7: a load edge puts the sampled start and upper bits on the outputs
    a_r2_load_capture: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (ofs_o == $past(start_i)) && (hi_o == $past(hi_i)));

    // R3: a sequential advance adds one, unless the order input moved
    a_r3_seq_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && adv_i && !mode_i) |=>
            (!$stable(mode_i) || load_i || ofs_o == $past(ofs_o) + OFS_W'(1)));

    // R5: at beat count zero, whether just loaded or after a full wrap, the offset is the start
    a_r5_wrap_to_start: assert property (@(posedge clk_i) disable iff (rst_i)
        (beats_seen == '0) |-> (ofs_o == start_seen));

    // R6: a wait state holds the offset while the order input is held
    a_r6_wait_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(load_i) && !$past(adv_i) && $stable(mode_i)) |-> $stable(ofs_o));

    // R8: the upper bits change only on a load edge
    a_r8_hi_held: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> $stable(hi_o));
endmodule

bind burst_seq_gen burst_seq_gen_chk #(.OFS_W(OFS_W), .HI_W(HI_W)) chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .load_i  (load_i),
    .adv_i   (adv_i),
    .mode_i  (mode_i),
    .start_i (start_i),
    .hi_i    (hi_i),
    .ofs_o   (ofs_o),
    .hi_o    (hi_o)
);

// File: tb/burst_seq_gen_tb_top.sv
module burst_seq_gen_tb_top;
    localparam int OFS_W = 2;
    localparam int HI_W  = 8;
    localparam int BEATS = 1 << OFS_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             load = 1'b0;
    logic             adv = 1'b0;
    logic             mode = 1'b1;
    logic [OFS_W-1:0] start = '0;
    logic [HI_W-1:0]  hi = '0;
    logic [OFS_W-1:0] ofs;
    logic [HI_W-1:0]  hi_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model state
    logic [OFS_W-1:0] m_start = '0;
    logic [OFS_W-1:0] m_k = '0;
    logic [HI_W-1:0]  m_hi = '0;

    always #4 clk = ~clk;

    burst_seq_gen #(.OFS_W(OFS_W), .HI_W(HI_W)) dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .load_i  (load),
        .adv_i   (adv),
        .mode_i  (mode),
        .start_i (start),
        .hi_i    (hi),
        .ofs_o   (ofs),
        .hi_o    (hi_out)
    );

    function automatic logic [OFS_W-1:0] exp_ofs(input logic md,
                                                 input logic [OFS_W-1:0] s,
                                                 input logic [OFS_W-1:0] k);
        if (md) return s ^ k;
        return OFS_W'((int'(s) + int'(k)) % BEATS);
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // one clock: drive at negedge, model update at posedge, compare 1 ns later
    task automatic step(input logic ld, input logic av, input logic md,
                        input logic [OFS_W-1:0] st, input logic [HI_W-1:0] h,
                        input string req);
        @(negedge clk);
        load = ld; adv = av; mode = md; start = st; hi = h;
        @(posedge clk);
        if (ld) begin
            m_start = st; m_k = '0; m_hi = h;
        end else if (av) begin
            m_k = m_k + OFS_W'(1);
        end
        #1;
        check(req, int'(ofs), int'(exp_ofs(md, m_start, m_k)));
        check("R8", int'(hi_out), int'(m_hi));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", int'(ofs), 0);
        check("R1", int'(hi_out), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1", int'(ofs), 0);

        // directed: every start in both orders, with a wait state and a wrap
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < BEATS; s++) begin
                step(1'b1, 1'b0, md[0], OFS_W'(s), HI_W'(8'hA0 + s + 16 * md), "R2");
                step(1'b0, 1'b1, md[0], '0, 8'h55, md ? "R4" : "R3");
                step(1'b0, 1'b0, md[0], '0, 8'h66, "R6");
                step(1'b0, 1'b1, md[0], '0, 8'h77, md ? "R4" : "R3");
                step(1'b0, 1'b1, md[0], '0, 8'h88, md ? "R4" : "R3");
                step(1'b0, 1'b1, md[0], '0, 8'h99, "R5");
                check("R5", int'(ofs), s);
                step(1'b0, 1'b1, md[0], '0, 8'hAA, md ? "R4" : "R3");
            end
        end

        // directed: sequential 01 -> 10 -> 11 -> 00, interleaved 10 -> 11 -> 00 -> 01
        step(1'b1, 1'b0, 1'b0, 2'b01, 8'h12, "R2");
        step(1'b0, 1'b1, 1'b0, '0, 8'h00, "R3");
        check("R3", int'(ofs), 2);
        step(1'b0, 1'b1, 1'b0, '0, 8'h00, "R3");
        check("R3", int'(ofs), 3);
        step(1'b0, 1'b1, 1'b0, '0, 8'h00, "R3");
        check("R3", int'(ofs), 0);
        step(1'b1, 1'b0, 1'b1, 2'b10, 8'h34, "R2");
        step(1'b0, 1'b1, 1'b1, '0, 8'h00, "R4");
        check("R4", int'(ofs), 3);
        step(1'b0, 1'b1, 1'b1, '0, 8'h00, "R4");
        check("R4", int'(ofs), 0);
        step(1'b0, 1'b1, 1'b1, '0, 8'h00, "R4");
        check("R4", int'(ofs), 1);

        // R7: load and advance together, mid-burst
        step(1'b0, 1'b1, 1'b1, '0, 8'h00, "R4");
        step(1'b1, 1'b1, 1'b1, 2'b11, 8'hC3, "R7");
        check("R7", int'(ofs), 3);
        step(1'b0, 1'b1, 1'b1, '0, 8'h00, "R7");
        check("R7", int'(ofs), 2);

        // random traffic; order changes only on a load
        for (int i = 0; i < 4000; i++) begin
            logic ld;
            logic av;
            logic md;
            ld = ($urandom % 8) == 0;
            av = $urandom % 2;
            md = ld ? 1'($urandom % 2) : mode;
            step(ld, av, md, OFS_W'($urandom), HI_W'($urandom),
                 ld ? (av ? "R7" : "R2") : (av ? (md ? "R4" : "R3") : "R6"));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule